// File: doc/BRIEF.md
# Scatter-Gather Table Walker

This block walks a table of scatter-gather descriptors in memory for one bus-master disk channel. Software writes the physical byte address of the table into the channel's register block, which drives it onto `table_base`, and then raises the run bit (`start`). While `start` stays high, the walker reads each descriptor as two 32-bit words through a simple read port. It decodes a buffer address and a byte length from the two words, hands that pair to a data mover as one transfer request, and waits for the mover to finish before it fetches the next descriptor.

Each descriptor is little-endian. The lower word is the buffer address. The upper word carries the length. The encoding of the length is chosen at build time by a parameter. In the standard encoding the low half-word is a byte count, a count of zero stands for 65536 bytes, and bit 31 flags the final entry. In the alternate encoding the high half-word holds the number of 32-bit words minus one, there is no final-entry flag, and an upper word that is all zeros ends the table.

The walker reports `active`, `done` and `error` back to the register block. A table that yields no usable entry, a misaligned table base, or an odd buffer address raises `error`, and no further transfer is started, so the driver can fall back to programmed I/O. Once the table is exhausted the walker holds `active` and `done` until software clears `start`.

Top module: `sg_table_walker`

## Requirements
- R1: After a synchronous active-low reset, `active`, `done`, `error`, `mem_req` and `xfer_valid` are all low.
- R2: With `start` high and `table_base[1:0]` equal to 0, the walker requests word addresses base+8k and then base+8k+4 for descriptor k, one word per `mem_rvalid`. Every requested address has bits 1:0 equal to 0.
- R3: In standard mode, `xfer_addr` equals the lower word. `xfer_len` equals upper word bits 15:0 when that field is nonzero, and 65536 when it is zero. Upper word bits 30:16 have no effect.
- R4: Each usable descriptor produces exactly one single-cycle `xfer_valid` pulse. No memory request is made from that pulse until `xfer_done` is seen.
- R5: In standard mode, upper word bit 31 marks the last entry. After that entry's `xfer_done`, no further fetch occurs, and `done` and `active` stay high until `start` falls.
- R6: In alternate mode, `xfer_len` equals (upper word bits 31:16 + 1) × 4. Bit 31 does not end the walk. An upper word of zero ends the walk with `done`, and that entry issues no transfer.
- R7: In alternate mode, a terminator as the very first descriptor raises `error` with no transfer issued, and `active` is low.
- R8: A table base whose bits 1:0 are nonzero raises `error` with no memory request. While `error` is high, `active`, `mem_req` and `xfer_valid` are low.
- R9: A descriptor whose buffer address has bit 0 set raises `error` instead of issuing a transfer. Transfers issued before it are kept.
- R10: If `start` falls while a descriptor is being fetched, `active` drops and no transfer is issued. If `start` falls while a transfer is outstanding, `active` stays high until that `xfer_done` arrives, then drops with no further fetch.
- R11: `done` and `error` are cleared, and `active` is low, within two cycles of `start` going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run bit; walk proceeds while high |
| table_base | input | 32 | Byte address of the descriptor table |
| mem_req | output | 1 | Read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Word address being read |
| mem_rvalid | input | 1 | Read data valid for the held request |
| mem_rdata | input | 32 | Read data word |
| xfer_valid | output | 1 | Single-cycle transfer request to the data mover |
| xfer_addr | output | 32 | Buffer address of the transfer |
| xfer_len | output | 19 | Transfer length in bytes |
| xfer_done | input | 1 | Data mover finished the outstanding transfer |
| active | output | 1 | Walk in progress or table exhausted while running |
| done | output | 1 | Table exhausted normally |
| error | output | 1 | Walk halted by a fault |

## Verification
Randomly built tables of one to six entries are walked in both encodings. The standard tables mix zero counts with random junk in bits 30:16, which separates the 65536 rule and the ignored bits from a plain copy of the word. The alternate tables mix all-ones counts with a set bit 31, which separates the word-count arithmetic and the terminator rule from the standard flag. Directed tables cover a misaligned base, an odd buffer address in mid-table, a terminator as the first entry, and run-bit removal both during a fetch and during an outstanding transfer. Together these tell an immediate abort apart from one that waits for the descriptor boundary.

// File: rtl/sgw_pkg.sv
// Shared constants and types for the scatter-gather table walker.
// Assumes 32-bit physical addresses and 32-bit memory words.
package sgw_pkg;
    localparam int PA_W       = 32;            // physical address width
    localparam int WORD_W     = 32;            // memory word width
    localparam int COUNT_W    = 16;            // count field width in a descriptor
    localparam int LEN_W      = COUNT_W + 3;   // bytes, enough for (2^16)*4
    localparam int DESC_BYTES = 8;             // two words per descriptor
    localparam int WORD_BYTES = WORD_W / 8;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH_LO,
        W_FETCH_HI,
        W_CHECK,
        W_ISSUE,
        W_WAIT,
        W_HOLD,
        W_FAULT
    } walk_state_t;
endpackage

// File: rtl/sgw_decode.sv
// Combinational decode of one two-word descriptor.
// ALT_MODE selects the length encoding: 0 = byte count with zero meaning
// 2^COUNT_W and bit 31 as last flag; 1 = (words-1) in the high half and an
// all-zero upper word as terminator. Assumes the words are already captured.
module sgw_decode
    import sgw_pkg::*;
#(
    parameter bit ALT_MODE = 1'b0
) (
    input  logic [WORD_W-1:0] word_lo,
    input  logic [WORD_W-1:0] word_hi,
    output logic [PA_W-1:0]   buf_addr,
    output logic [LEN_W-1:0]  len,
    output logic              last,
    output logic              term,
    output logic              misalign
);
    // Buffer address and its alignment are common to both encodings.
    assign buf_addr = word_lo[PA_W-1:0];
    assign misalign = word_lo[0];

    generate
        if (ALT_MODE) begin : g_alt
            logic [LEN_W-1:0] words;
            // Word count is field+1; length in bytes is four times that.
            assign words = LEN_W'(word_hi[WORD_W-1 -: COUNT_W]) + LEN_W'(1);
            assign len   = words << 2;
            assign last  = 1'b0;
            assign term  = (word_hi == '0);
        end else begin : g_std
            logic unused_hi;
            // Zero count expands to the full 2^COUNT_W bytes.
            assign len  = (word_hi[COUNT_W-1:0] == '0)
                          ? (LEN_W'(1) << COUNT_W)
                          : LEN_W'(word_hi[COUNT_W-1:0]);
            assign last = word_hi[WORD_W-1];
            assign term = 1'b0;
            assign unused_hi = ^word_hi[WORD_W-2:COUNT_W];
        end
    endgenerate
endmodule

// File: rtl/sgw_ptr.sv
// Descriptor pointer: loaded with the table base, advanced one descriptor
// at a time, and offset by one word for the upper half of a descriptor.
// Assumes load and advance are never asserted together.
module sgw_ptr
    import sgw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            advance,
    input  logic            hi_sel,
    input  logic [PA_W-1:0] base,
    output logic [PA_W-1:0] fetch_addr
);
    logic [PA_W-1:0] ptr_q;

    // Holds the byte address of the descriptor being fetched.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (load)    ptr_q <= base;
        else if (advance) ptr_q <= ptr_q + PA_W'(DESC_BYTES);
    end

    // Lower word at the pointer, upper word one word above.
    assign fetch_addr = ptr_q + (hi_sel ? PA_W'(WORD_BYTES) : PA_W'(0));
endmodule

// File: rtl/sgw_fsm.sv
// Walk sequencer: fetch two words, check, issue, wait, repeat.
// Assumes the descriptor flags are valid from the cycle after both words
// are captured, and that xfer_done only follows an issued transfer.
module sgw_fsm
    import sgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        base_misalign,
    input  logic        rvalid,
    input  logic        xfer_done,
    input  logic        d_last,
    input  logic        d_term,
    input  logic        d_misalign,
    output walk_state_t state,
    output logic        load_ptr,
    output logic        adv_ptr,
    output logic        cap_lo,
    output logic        cap_hi
);
    walk_state_t nxt;
    logic        first_q;

    // Next-state and strobe generation.
    always_comb begin
        nxt      = state;
        load_ptr = 1'b0;
        adv_ptr  = 1'b0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        unique case (state)
            W_IDLE: if (start) begin
                if (base_misalign) nxt = W_FAULT;
                else begin
                    nxt      = W_FETCH_LO;
                    load_ptr = 1'b1;
                end
            end
            W_FETCH_LO: begin
                if (!start) nxt = W_IDLE;
                else if (rvalid) begin
                    cap_lo = 1'b1;
                    nxt    = W_FETCH_HI;
                end
            end
            W_FETCH_HI: begin
                if (!start) nxt = W_IDLE;
                else if (rvalid) begin
                    cap_hi = 1'b1;
                    nxt    = W_CHECK;
                end
            end
            W_CHECK: begin
                if (!start)          nxt = W_IDLE;
                else if (d_term)     nxt = first_q ? W_FAULT : W_HOLD;
                else if (d_misalign) nxt = W_FAULT;
                else                 nxt = W_ISSUE;
            end
            W_ISSUE: nxt = W_WAIT;
            W_WAIT: if (xfer_done) begin
                if (!start)      nxt = W_IDLE;
                else if (d_last) nxt = W_HOLD;
                else begin
                    nxt     = W_FETCH_LO;
                    adv_ptr = 1'b1;
                end
            end
            W_HOLD, W_FAULT: if (!start) nxt = W_IDLE;
            default: nxt = W_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nxt;
    end

    // Marks that no transfer has been issued yet in this walk.
    always_ff @(posedge clk) begin
        if (!rst_n)              first_q <= 1'b0;
        else if (load_ptr)       first_q <= 1'b1;
        else if (state == W_ISSUE) first_q <= 1'b0;
    end
endmodule

// File: rtl/sg_table_walker.sv
// Scatter-gather table walker for a bus-master disk channel.
// Reads two-word descriptors from table_base upward, issues one transfer
// per usable entry and waits for its completion before the next fetch.
// Assumes the memory port holds data valid for one cycle per request and
// that start stays high for the whole walk unless an abort is intended.
module sg_table_walker
    import sgw_pkg::*;
#(
    parameter bit ALT_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PA_W-1:0]  table_base,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic             xfer_valid,
    output logic [PA_W-1:0]  xfer_addr,
    output logic [LEN_W-1:0] xfer_len,
    input  logic             xfer_done,
    output logic             active,
    output logic             done,
    output logic             error
);
    walk_state_t state;
    logic        load_ptr, adv_ptr, cap_lo, cap_hi;
    logic        d_last, d_term, d_misalign;
    logic [WORD_W-1:0] word_lo_q, word_hi_q;

    // Captures the two descriptor words as they return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_lo_q <= '0;
            word_hi_q <= '0;
        end else begin
            if (cap_lo) word_lo_q <= mem_rdata;
            if (cap_hi) word_hi_q <= mem_rdata;
        end
    end

    sgw_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .base_misalign(table_base[1:0] != 2'b00),
        .rvalid       (mem_rvalid),
        .xfer_done    (xfer_done),
        .d_last       (d_last),
        .d_term       (d_term),
        .d_misalign   (d_misalign),
        .state        (state),
        .load_ptr     (load_ptr),
        .adv_ptr      (adv_ptr),
        .cap_lo       (cap_lo),
        .cap_hi       (cap_hi)
    );

    sgw_ptr u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ptr),
        .advance   (adv_ptr),
        .hi_sel    (state == W_FETCH_HI),
        .base      (table_base),
        .fetch_addr(mem_addr)
    );

    sgw_decode #(.ALT_MODE(ALT_MODE)) u_dec (
        .word_lo (word_lo_q),
        .word_hi (word_hi_q),
        .buf_addr(xfer_addr),
        .len     (xfer_len),
        .last    (d_last),
        .term    (d_term),
        .misalign(d_misalign)
    );

    // Port-level status decoded from the walk state.
    assign mem_req    = (state == W_FETCH_LO) || (state == W_FETCH_HI);
    assign xfer_valid = (state == W_ISSUE);
    assign active     = (state != W_IDLE) && (state != W_FAULT);
    assign done       = (state == W_HOLD);
    assign error      = (state == W_FAULT);
endmodule

// File: rtl/sg_table_walker_chk.sv
// Port-level protocol checker for sg_table_walker, attached by bind.
// Assumes xfer_done is only returned for an issued transfer.
module sg_table_walker_chk
    import sgw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mem_req,
    input logic [PA_W-1:0]  mem_addr,
    input logic             xfer_valid,
    input logic [PA_W-1:0]  xfer_addr,
    input logic [LEN_W-1:0] xfer_len,
    input logic             xfer_done,
    input logic             active,
    input logic             done,
    input logic             error
);
    logic outstanding_q;
    logic unused_chk;

    // Tracks a transfer between its request pulse and its completion.
    always_ff @(posedge clk) begin
        if (!rst_n)          outstanding_q <= 1'b0;
        else if (xfer_valid) outstanding_q <= 1'b1;
        else if (xfer_done)  outstanding_q <= 1'b0;
    end

    assign unused_chk = ^{mem_addr[PA_W-1:2], xfer_addr[PA_W-1:1]};

    assert_word_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (xfer_len != '0 && xfer_len <= (LEN_W'(1) << (COUNT_W + 2))));
    assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> !xfer_valid);
    assert_no_refetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding_q |-> !mem_req);
    assert_done_keeps_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (active && !error));
    assert_fault_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!active && !mem_req && !xfer_valid));
    assert_even_buffer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !xfer_addr[0]);
    assert_stay_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !active) |=> !active);
    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && (done || error)) |=> !(done || error));
endmodule

bind sg_table_walker sg_table_walker_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .xfer_valid(xfer_valid),
    .xfer_addr (xfer_addr),
    .xfer_len  (xfer_len),
    .xfer_done (xfer_done),
    .active    (active),
    .done      (done),
    .error     (error)
);

// File: tb/sg_table_walker_tb_top.sv
`timescale 1ns/1ps
module sg_table_walker_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        use_alt = 1'b0;
    logic        s_start = 1'b0, a_start = 1'b0;
    logic [31:0] base_r = '0;
    logic        m_rvalid = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        x_done = 1'b0;

    logic        s_req, a_req, s_xv, a_xv, s_act, a_act, s_dn, a_dn, s_er, a_er;
    logic [31:0] s_maddr, a_maddr, s_xa, a_xa;
    logic [18:0] s_xl, a_xl;

    sg_table_walker #(.ALT_MODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(s_start), .table_base(base_r),
        .mem_req(s_req), .mem_addr(s_maddr), .mem_rvalid(m_rvalid), .mem_rdata(m_rdata),
        .xfer_valid(s_xv), .xfer_addr(s_xa), .xfer_len(s_xl), .xfer_done(x_done),
        .active(s_act), .done(s_dn), .error(s_er));

    sg_table_walker #(.ALT_MODE(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .start(a_start), .table_base(base_r),
        .mem_req(a_req), .mem_addr(a_maddr), .mem_rvalid(m_rvalid), .mem_rdata(m_rdata),
        .xfer_valid(a_xv), .xfer_addr(a_xa), .xfer_len(a_xl), .xfer_done(x_done),
        .active(a_act), .done(a_dn), .error(a_er));

    // Selected-DUT view.
    wire        m_req  = use_alt ? a_req   : s_req;
    wire [31:0] m_addr = use_alt ? a_maddr : s_maddr;
    wire        xv     = use_alt ? a_xv    : s_xv;
    wire [31:0] xa     = use_alt ? a_xa    : s_xa;
    wire [18:0] xl     = use_alt ? a_xl    : s_xl;
    wire        st_act = use_alt ? a_act   : s_act;
    wire        st_dn  = use_alt ? a_dn    : s_dn;
    wire        st_er  = use_alt ? a_er    : s_er;

    logic [31:0] mem [0:1023];
    logic [31:0] tw0 [0:15];
    logic [31:0] tw1 [0:15];
    logic [31:0] flog [0:63];
    logic [31:0] xalog [0:31];
    logic [18:0] xllog [0:31];
    int fn = 0, xn = 0;
    int m_dly = 0, x_cnt = 0;
    logic x_pend = 1'b0, mover_hold = 1'b0;

    int n_checks = 0, n_fail = 0;

    // Memory and data-mover models, acting away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_rvalid = 1'b0; x_done = 1'b0; x_pend = 1'b0;
        end else begin
            if (m_rvalid) m_rvalid = 1'b0;
            else if (m_req) begin
                if (m_dly == 0) begin
                    m_rvalid = 1'b1;
                    m_rdata  = mem[m_addr[11:2]];
                    if (fn < 64) flog[fn] = m_addr;
                    fn++;
                    m_dly = $urandom % 3;
                end else m_dly--;
            end
            if (x_done) x_done = 1'b0;
            else if (xv) begin
                if (xn < 32) begin xalog[xn] = xa; xllog[xn] = xl; end
                xn++;
                x_cnt = $urandom % 4;
                x_pend = 1'b1;
            end else if (x_pend && !mover_hold) begin
                if (x_cnt == 0) begin x_done = 1'b1; x_pend = 1'b0; end
                else x_cnt--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [18:0] exp_len(input bit alt, input logic [31:0] w1);
        if (alt) return (19'(w1[31:16]) + 19'd1) * 19'd4;
        if (w1[15:0] == 16'h0) return 19'h10000;
        return 19'(w1[15:0]);
    endfunction

    task automatic set_start(input bit v);
        if (use_alt) a_start = v; else s_start = v;
    endtask

    // Walk a table held in tw0/tw1 and compare against bench expectations.
    task automatic run_walk(input bit alt, input logic [31:0] base, input int n, input string tag);
        logic [31:0] ea [0:15];
        logic [18:0] el [0:15];
        int en = 0, efetch = 0, guard = 0, f_snap;
        bit edone = 0, eerr = 0;
        for (int k = 0; k < n; k++) begin
            mem[((base & ~32'h3) >> 2) + 2*k]     = tw0[k];
            mem[((base & ~32'h3) >> 2) + 2*k + 1] = tw1[k];
        end
        if (base[1:0] != 2'b00) eerr = 1;
        else for (int k = 0; k < n; k++) begin
            efetch += 2;
            if (alt && tw1[k] == 32'h0) begin
                if (k == 0) eerr = 1; else edone = 1;
                break;
            end
            if (tw0[k][0]) begin eerr = 1; break; end
            ea[en] = tw0[k]; el[en] = exp_len(alt, tw1[k]); en++;
            if (!alt && tw1[k][31]) begin edone = 1; break; end
        end
        @(negedge clk);
        use_alt = alt; base_r = base; fn = 0; xn = 0;
        set_start(1'b1);
        while (!(st_dn || st_er) && guard < 4000) begin @(negedge clk); guard++; end
        chk(xn == en, alt ? "R6" : "R3", {tag, " transfer count"}, xn, en);
        for (int k = 0; k < en && k < xn; k++) begin
            chk(xalog[k] == ea[k], alt ? "R6" : "R3", {tag, " xfer_addr"}, xalog[k], ea[k]);
            chk(xllog[k] == el[k], alt ? "R6" : "R3", {tag, " xfer_len"}, xllog[k], el[k]);
        end
        chk(fn == efetch, "R2", {tag, " fetch count"}, fn, efetch);
        for (int k = 0; k < efetch && k < fn; k++)
            chk(flog[k] == base + 32'(4*k), "R2", {tag, " fetch addr"}, flog[k], base + 32'(4*k));
        chk(st_dn == edone, alt ? "R6" : "R5", {tag, " done"}, st_dn, edone);
        chk(st_er == eerr, eerr ? "R8" : "R5", {tag, " error"}, st_er, eerr);
        chk(st_act == edone, "R5", {tag, " active"}, st_act, edone);
        if (edone) begin
            f_snap = fn;
            repeat (4) @(negedge clk);
            chk(st_act && st_dn && fn == f_snap, "R5", {tag, " hold until start low"}, fn, f_snap);
        end
        set_start(1'b0);
        repeat (2) @(negedge clk);
        chk(!st_act && !st_dn && !st_er, "R11", {tag, " release"}, {st_act, st_dn, st_er}, 0);
    endtask

    initial begin
        int unsigned seed_sink;
        int n;
        seed_sink = $urandom(32'h1ce5eed);
        for (int i = 0; i < 1024; i++) mem[i] = 32'hdead_0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state on both variants
        chk(!s_act && !s_dn && !s_er && !s_req && !s_xv, "R1", "std reset outputs",
            {s_act, s_dn, s_er, s_req, s_xv}, 0);
        chk(!a_act && !a_dn && !a_er && !a_req && !a_xv, "R1", "alt reset outputs",
            {a_act, a_dn, a_er, a_req, a_xv}, 0);

        // Random standard tables: zero counts, junk in bits 30:16 (R3, R5)
        for (int it = 0; it < 8; it++) begin
            n = 1 + $urandom % 6;
            for (int k = 0; k < n; k++) begin
                tw0[k] = $urandom & 32'hffff_fffe;
                tw1[k] = {1'b0, 15'($urandom), ($urandom % 4 == 0) ? 16'h0 : 16'($urandom)};
                if (k == n - 1) tw1[k][31] = 1'b1;
            end
            run_walk(1'b0, 32'(($urandom % 240) * 4), n, "std random");
        end

        // Random alternate tables: max counts, bit 31 set, terminator (R6)
        for (int it = 0; it < 8; it++) begin
            n = 1 + $urandom % 5;
            for (int k = 0; k < n; k++) begin
                tw0[k] = $urandom & 32'hffff_fffe;
                tw1[k] = {($urandom % 3 == 0) ? 16'hffff : 16'($urandom), 16'($urandom) | 16'h1};
            end
            tw1[0][31] = 1'b1;
            tw0[n] = $urandom; tw1[n] = 32'h0;
            run_walk(1'b1, 32'(($urandom % 240) * 4), n + 1, "alt random");
        end

        // R7: terminator first in alternate mode
        tw0[0] = 32'h0000_1000; tw1[0] = 32'h0;
        run_walk(1'b1, 32'h100, 1, "R7 empty table");

        // R8: misaligned table base
        tw0[0] = 32'h2000; tw1[0] = 32'h8000_0010;
        run_walk(1'b0, 32'h102, 1, "R8 base misaligned");

        // R9: odd buffer address on the second entry
        tw0[0] = 32'h3000; tw1[0] = 32'h0000_0200;
        tw0[1] = 32'h3401; tw1[1] = 32'h0000_0200;
        tw0[2] = 32'h3800; tw1[2] = 32'h8000_0200;
        run_walk(1'b0, 32'h200, 3, "R9 odd buffer");

        // R3 boundary: single descriptor of 65536 bytes with last flag
        tw0[0] = 32'h0001_0000; tw1[0] = 32'h8000_0000;
        run_walk(1'b0, 32'h300, 1, "R3 full count");

        // R10: abort while fetching
        tw0[0] = 32'h4000; tw1[0] = 32'h8000_0040;
        mem[32'h400 >> 2] = tw0[0]; mem[(32'h400 >> 2) + 1] = tw1[0];
        @(negedge clk);
        use_alt = 1'b0; base_r = 32'h400; fn = 0; xn = 0;
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        repeat (2) @(negedge clk);
        chk(!s_act, "R10", "fetch abort active", s_act, 0);
        repeat (10) @(negedge clk);
        chk(xn == 0, "R10", "fetch abort no transfer", xn, 0);

        // R10: abort while a transfer is outstanding
        for (int k = 0; k < 3; k++) begin
            tw0[k] = 32'h5000 + 32'(k * 32'h100);
            tw1[k] = 32'h0000_0080;
            mem[(32'h500 >> 2) + 2*k] = tw0[k]; mem[(32'h500 >> 2) + 2*k + 1] = tw1[k];
        end
        mover_hold = 1'b1;
        base_r = 32'h500; fn = 0; xn = 0;
        s_start = 1'b1;
        for (int g = 0; g < 200 && xn == 0; g++) @(negedge clk);
        s_start = 1'b0;
        repeat (5) @(negedge clk);
        chk(s_act, "R10", "active held until boundary", s_act, 1);
        mover_hold = 1'b0;
        for (int g = 0; g < 20 && s_act; g++) @(negedge clk);
        chk(!s_act, "R10", "active dropped at boundary", s_act, 0);
        repeat (4) @(negedge clk);
        chk(fn == 2 && xn == 1, "R10", "no fetch after abort", fn, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule